// File: doc/BRIEF.md
# Cumulative Warning Lamp Sequencer

This block steps a roadside warning sign through a repeating build-up of five lamps. The lamps are wired in three groups: a low group (lamps 1 and 2), a middle group (lamps 3 and 4) and a top lamp (lamp 5). While the operate switch is on, each accepted step lights one more group, until all five lamps are lit. The step after that turns every lamp off and the cycle starts again.

The sequencer is a Moore machine with a two-bit state held in edge-triggered flip-flops. The lamp outputs are registered and depend only on the stored state. The operate switch works as a synchronous clear: on any clock edge where it is off, the machine goes to the dark state, whatever the step enable says. A step-enable input lets a slow blink strobe, made elsewhere from the fast system clock, set the pace. Tie it high to advance on every clock.

Top module: `lamp_sequencer`

## Requirements
- R1: On a clock edge with `rst` high, the block enters the dark state and all three lamp outputs are 0 after that edge.
- R2: The lamp outputs, written as the vector {lamp_top, lamp_mid, lamp_low}, only take the values 3'b000 (dark), 3'b001 (stage one: lamps 1 and 2), 3'b011 (stage two: lamps 1 to 4) and 3'b111 (stage three: all five). A lit top lamp implies a lit middle group, and a lit middle group implies a lit low group.
- R3: On an edge with `rst` low, `operate` high and `tick_en` high, the lamps advance one step in the fixed order 000, 001, 011, 111 and back to 000.
- R4: On an edge with `rst` low and `operate` low, the lamps become 3'b000, whatever the value of `tick_en`.
- R5: On an edge with `rst` low, `operate` high and `tick_en` low, the lamp outputs keep their value.
- R6: `rst` takes priority over `operate` and `tick_en`: the lamps are dark after a reset edge, even with both of those inputs high.
- R7: When `operate` goes high again after being low, the first accepted step lights stage one (3'b001). The build-up restarts from the beginning and does not resume where it was cleared.
- R8: The lamp outputs are registered. They change only in response to a rising edge of `clk` and hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the dark state |
| tick_en | input | 1 | Step enable; while high, the sequence may advance on this edge |
| operate | input | 1 | Operate switch; low clears the sequence to dark at the edge |
| lamp_low | output | 1 | Drive for lamps 1 and 2 |
| lamp_mid | output | 1 | Drive for lamps 3 and 4 |
| lamp_top | output | 1 | Drive for lamp 5 |

## Verification
On every cycle, the assertions check the nesting of the lamp groups, the dark result after a reset or a switch-off edge, the single-step advance from each of the four lamp patterns, and the hold while the step enable is low. Only the bench's scenarios can show the whole cyclic order over several passes. The same holds for the restart at stage one after a clear in the middle of a build-up, reset winning over both other inputs, and the lamps staying steady between edges while inputs change. The bench plays an irregular step-enable pattern and compares every edge against a model that does not depend on the design.

// File: rtl/lamp_seq_pkg.sv
package lamp_seq_pkg;

  localparam int STATE_W = 2;
  localparam int LAMP_W  = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_DARK  = 2'b00,
    ST_ONE   = 2'b01,
    ST_TWO   = 2'b10,
    ST_THREE = 2'b11
  } seq_state_t;

  typedef struct packed {
    logic top;
    logic mid;
    logic low;
  } lamp_vec_t;

endpackage

// File: rtl/lamp_seq_next.sv
module lamp_seq_next
  import lamp_seq_pkg::*;
(
  input  seq_state_t cur_state,
  input  logic       operate,
  input  logic       tick_en,
  output seq_state_t nxt_state
);

  always_comb begin
    if (!operate) begin
      nxt_state = ST_DARK;
    end else if (tick_en) begin
      nxt_state = seq_state_t'(cur_state + 2'd1);
    end else begin
      nxt_state = cur_state;
    end
  end

endmodule

// File: rtl/lamp_seq_decode.sv
module lamp_seq_decode
  import lamp_seq_pkg::*;
(
  input  seq_state_t st,
  output lamp_vec_t  lamps
);

  always_comb begin
    lamps.low = st[1] | st[0];
    lamps.mid = st[1];
    lamps.top = st[1] & st[0];
  end

endmodule

// File: rtl/lamp_sequencer.sv
module lamp_sequencer
  import lamp_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic operate,
  output logic lamp_low,
  output logic lamp_mid,
  output logic lamp_top
);

  seq_state_t state_q;
  seq_state_t state_d;
  lamp_vec_t  lamps_d;
  lamp_vec_t  lamps_q;

  lamp_seq_next u_next (
    .cur_state (state_q),
    .operate   (operate),
    .tick_en   (tick_en),
    .nxt_state (state_d)
  );

  // Decode from the next state so the registered lamps line up with state_q.
  lamp_seq_decode u_decode (
    .st    (state_d),
    .lamps (lamps_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_DARK;
      lamps_q <= '0;
    end else begin
      state_q <= state_d;
      lamps_q <= lamps_d;
    end
  end

  assign lamp_low = lamps_q.low;
  assign lamp_mid = lamps_q.mid;
  assign lamp_top = lamps_q.top;

endmodule

// File: rtl/lamp_sequencer_chk.sv
module lamp_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic tick_en,
  input logic operate,
  input logic lamp_low,
  input logic lamp_mid,
  input logic lamp_top
);

  logic [2:0] pat;
  assign pat = {lamp_top, lamp_mid, lamp_low};

  // R1 / R6: a reset edge leaves the lamps dark
  a_r1_reset_dark: assert property (@(posedge clk) rst |=> (pat == 3'b000));

  // R2: lamp groups are nested
  a_r2_nested: assert property (@(posedge clk) disable iff (rst)
    ((!lamp_top || lamp_mid) && (!lamp_mid || lamp_low)));

  // R3: one step forward from each pattern
  a_r3_step_dark: assert property (@(posedge clk) disable iff (rst)
    (operate && tick_en && pat == 3'b000) |=> (pat == 3'b001));
  a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
    (operate && tick_en && pat == 3'b001) |=> (pat == 3'b011));
  a_r3_step_two: assert property (@(posedge clk) disable iff (rst)
    (operate && tick_en && pat == 3'b011) |=> (pat == 3'b111));
  a_r3_step_all: assert property (@(posedge clk) disable iff (rst)
    (operate && tick_en && pat == 3'b111) |=> (pat == 3'b000));

  // R4: switch off clears at the edge
  a_r4_off_dark: assert property (@(posedge clk) disable iff (rst)
    !operate |=> (pat == 3'b000));

  // R5: no step enable means hold
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (operate && !tick_en) |=> $stable(pat));

endmodule

bind lamp_sequencer lamp_sequencer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_en  (tick_en),
  .operate  (operate),
  .lamp_low (lamp_low),
  .lamp_mid (lamp_mid),
  .lamp_top (lamp_top)
);

// File: tb/lamp_sequencer_bench.sv
`timescale 1ns/1ps
module lamp_sequencer_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic operate = 1'b0;
  logic lamp_low, lamp_mid, lamp_top;

  always #2 clk = ~clk;  // 250 MHz

  lamp_sequencer u_lamp_sequencer (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .operate  (operate),
    .lamp_low (lamp_low),
    .lamp_mid (lamp_mid),
    .lamp_top (lamp_top)
  );

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int model_stage = 0;
  bit done = 1'b0;

  function automatic logic [2:0] stage_pat(input int s);
    case (s)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lamps act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: sets inputs away from the edge and pushes the expected result.
  task automatic step(input bit r, input bit op, input bit tk, input string tag);
    item_t it;
    @(negedge clk);
    rst = r;
    operate = op;
    tick_en = tk;
    if (r || !op) model_stage = 0;
    else if (tk) model_stage = (model_stage + 1) % 4;
    it.exp = stage_pat(model_stage);
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: pops and compares just after each edge.
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check({lamp_top, lamp_mid, lamp_low}, it.exp, it.tag);
    end
  end

  initial begin
    logic [7:0] lfsr;
    step(1, 1, 1, "R1/R6 reset with inputs high");
    step(1, 0, 0, "R1 reset");
    for (int i = 0; i < 9; i++) step(0, 1, 1, "R3/R2 advance");
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R5 hold");
    step(0, 0, 1, "R4 off with tick high");
    step(0, 0, 0, "R4 off with tick low");
    step(0, 1, 1, "R7 restart at stage one");
    step(0, 1, 1, "R3 advance");
    step(0, 0, 0, "R4 clear mid build-up");
    step(0, 1, 0, "R5 hold dark");
    step(0, 1, 1, "R7 restart at stage one");
    step(0, 1, 1, "R3 advance");
    step(1, 1, 1, "R6 reset wins");
    lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(0, (i % 13) != 12, lfsr[0], "R3/R4/R5 irregular pattern");
    end
    // R8: inputs move between edges; outputs must not follow until the edge
    step(0, 1, 0, "R5 hold before R8");
    @(negedge clk);
    begin
      logic [2:0] held;
      #1;
      held = {lamp_top, lamp_mid, lamp_low};
      operate = 1'b0;
      rst = 1'b1;
      #0.5;
      check({lamp_top, lamp_mid, lamp_low}, held, "R8 steady between edges");
      operate = 1'b1;
      rst = 1'b0;
      tick_en = 1'b0;
    end
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule